// File: doc/BRIEF.md
# Compare and Gated Interval Timer

This block is a 16-bit up-counter with a power-of-two clock divider. A synchronous byte-wide write port programs it. It runs in one of two modes. In compare mode it counts freely. Each time the count equals a programmed match value, it raises an interrupt and may invert its output pin. Counting carries on past the match and wraps from FFFFh to 0000h, so the next match comes only after a full wrap.

In gated mode the counter advances only while an external gate input, after synchronisation, sits at a programmed active level. When the count reaches the match value it restarts at 0001h. A two-bit source field sets what raises the interrupt: the gate falling from active to inactive, the restart, or both.

Software sets up the divider, the interrupt source, the initial output level, the start count and the match value while the timer is stopped, and then sets the run bit. The write port has no handshake and every write is taken in the cycle it is presented. Writes to locked registers are dropped without notice.

Top module: `cmpgate_timer`

## Requirements
- R1: After reset, the count and the match value are 0000h, the output is low, the interrupt pulse is low and the sticky flag is clear.
- R2: While stopped, a write to address 0 loads the count high byte, address 1 the count low byte, address 2 the match high byte and address 3 the match low byte.
- R3: While running (run bit set), writes to addresses 0 to 4 have no effect.
- R4: The setup register sits at address 4. Bits [2:0] hold the divider exponent N, bit 3 the initial output level, bits [5:4] the gated interrupt source. The count steps once every 2^N clocks. The first step comes 2^N clocks after the edge that sets the run bit.
- R5: In compare mode (mode bit 0), a step taken while count equals the match value produces a one-cycle interrupt pulse. The count still advances to match+1.
- R6: The control register sits at address 5: bit 0 run, bit 1 mode, bit 2 gate active level, bit 3 output enable. On a match step the output inverts when output enable is 1 and holds when it is 0. A setup write while stopped loads the output from bit 3.
- R7: The count wraps from FFFFh to 0000h on a step.
- R8: In gated mode (mode bit 1), the count steps only while the gate input, delayed by two flops, equals the active level bit. A gate held active for G clock edges gives exactly G steps.
- R9: In gated mode, a step taken while count equals the match value sets the count to 0001h. If setup bit 5 is 1 it pulses the interrupt, and it inverts the output if output enable is 1.
- R10: In gated mode with setup bit 4 set, the synchronised gate moving from active to inactive pulses the interrupt. With bit 4 clear, this transition raises no interrupt.
- R11: The sticky flag sets with every interrupt pulse. Writing 1 to bit 0 of address 6 clears it, writing 0 leaves it, and a new pulse wins over a clear.
- R12: Clearing the run bit freezes the count and resets the divider. After the run bit is set again, the first step comes 2^N clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| gate_in | input | 1 | Asynchronous gate input |
| tmr_out | output | 1 | Timer output level |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |
| count_q | output | 16 | Current count |
| reload_q | output | 16 | Current match value |

## Verification
A register write is visible one edge after it is presented. With the run bit set at edge E, step k lands at edge E+k·2^N, and that step's interrupt pulse, output change and flag update appear on the same edge. In gated mode, a gate raised before edge a gives steps at edges a+2 through a+G+1, and its deassertion interrupt comes at edge a+G+2. Every check drives on a falling edge and samples on a falling edge after counting the rising edges up to the predicted one. Each result is therefore compared in the exact cycle it is due, together with the cycle before where a change must not yet show.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam int CNT_W = 16;
  localparam int EXP_W = 3;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] A_CNT_HI = 3'd0;
  localparam logic [ADR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADR_W-1:0] A_MAT_HI = 3'd2;
  localparam logic [ADR_W-1:0] A_MAT_LO = 3'd3;
  localparam logic [ADR_W-1:0] A_SETUP  = 3'd4;
  localparam logic [ADR_W-1:0] A_CTRL   = 3'd5;
  localparam logic [ADR_W-1:0] A_STAT   = 3'd6;

  typedef enum logic {MODE_CMP = 1'b0, MODE_GATE = 1'b1} tmode_e;

  typedef struct packed {
    logic [1:0]       src;
    logic             lvl;
    logic [EXP_W-1:0] exp;
  } setup_t;

  typedef struct packed {
    logic   oe;
    logic   pol;
    tmode_e mode;
    logic   run;
  } ctrl_t;
endpackage

// File: rtl/cgt_prescaler.sv
module cgt_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (exp > EXP_W'(i));
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && exp != '0) |=> !tick);
endmodule

// File: rtl/cgt_gate_sync.sv
module cgt_gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic pol,
  output logic active,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= gate_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign active = (s2_q == pol);
  assign fall   = (s3_q == pol) && (s2_q != pol);
endmodule

// File: rtl/cgt_core.sv
module cgt_core
  import cgt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  tmode_e       mode,
  input  logic         tick,
  input  logic         gate_act,
  input  logic         gate_fall,
  input  logic         oe,
  input  logic [1:0]   src,
  input  logic [W-1:0] match,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [7:0]   wr_byte,
  input  logic         lvl_load,
  input  logic         lvl_val,
  output logic [W-1:0] cnt_q,
  output logic         out_q,
  output logic         irq_evt,
  output logic         irq_q
);
  logic hit, step, match_evt;

  assign hit       = (cnt_q == match);
  assign step      = tick && (mode == MODE_CMP || gate_act);
  assign match_evt = step && hit;

  always_comb begin
    if (mode == MODE_CMP) irq_evt = match_evt;
    else irq_evt = (src[1] && match_evt) || (src[0] && run && gate_fall);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) cnt_q[W-1:8] <= wr_byte[W-9:0];
      if (wr_lo) cnt_q[7:0]   <= wr_byte;
    end else if (step) begin
      if (mode == MODE_GATE && hit) cnt_q <= W'(1);
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_evt;
      if (lvl_load)             out_q <= lvl_val;
      else if (match_evt && oe) out_q <= ~out_q;
    end
  end

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '1 && !(mode == MODE_GATE && hit)) |=> cnt_q == '0);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == MODE_GATE && hit) |=> cnt_q == W'(1));
  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_GATE && !gate_act) |=> $stable(cnt_q));
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && oe && !lvl_load) |=> out_q != $past(out_q));
  assert_pass_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_CMP) |=> (irq_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmpgate_timer.sv
module cmpgate_timer
  import cgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        gate_in,
  output logic        tmr_out,
  output logic        irq_pulse,
  output logic        irq_flag,
  output logic [15:0] count_q,
  output logic [15:0] reload_q
);
  setup_t setup_q;
  ctrl_t  ctrl_q;
  logic   cfg_ok;
  logic   wr_cnt_hi, wr_cnt_lo, wr_mat_hi, wr_mat_lo, wr_setup, wr_ctrl, wr_stat;
  logic   tick, gate_act, gate_fall, irq_evt;

  assign cfg_ok = wr_en && !ctrl_q.run;

  always_comb begin
    wr_cnt_hi = cfg_ok && wr_addr == A_CNT_HI;
    wr_cnt_lo = cfg_ok && wr_addr == A_CNT_LO;
    wr_mat_hi = cfg_ok && wr_addr == A_MAT_HI;
    wr_mat_lo = cfg_ok && wr_addr == A_MAT_LO;
    wr_setup  = cfg_ok && wr_addr == A_SETUP;
    wr_ctrl   = wr_en  && wr_addr == A_CTRL;
    wr_stat   = wr_en  && wr_addr == A_STAT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      setup_q  <= '0;
      ctrl_q   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_mat_hi) reload_q[CNT_W-1:8] <= wr_data;
      if (wr_mat_lo) reload_q[7:0]       <= wr_data;
      if (wr_setup)  setup_q <= setup_t'(wr_data[5:0]);
      if (wr_ctrl)   ctrl_q  <= ctrl_t'(wr_data[3:0]);
      if (irq_evt)                   irq_flag <= 1'b1;
      else if (wr_stat && wr_data[0]) irq_flag <= 1'b0;
    end
  end

  cgt_prescaler #(.EXP_W(EXP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .exp(setup_q.exp), .tick(tick)
  );

  cgt_gate_sync u_gate (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .pol(ctrl_q.pol),
    .active(gate_act), .fall(gate_fall)
  );

  cgt_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .mode(ctrl_q.mode), .tick(tick),
    .gate_act(gate_act), .gate_fall(gate_fall), .oe(ctrl_q.oe), .src(setup_q.src),
    .match(reload_q), .wr_hi(wr_cnt_hi), .wr_lo(wr_cnt_lo), .wr_byte(wr_data),
    .lvl_load(wr_setup), .lvl_val(wr_data[3]), .cnt_q(count_q), .out_q(tmr_out),
    .irq_evt(irq_evt), .irq_q(irq_pulse)
  );

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run |=> $stable(reload_q));
  assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_cnt_hi && !wr_cnt_lo) |=> $stable(count_q));
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
endmodule

// File: tb/cmpgate_timer_bench.sv
`timescale 1ns/1ps
module cmpgate_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        gate_in = 1'b0;
  logic        tmr_out, irq_pulse, irq_flag;
  logic [15:0] count_q, reload_q;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cmpgate_timer u_cmpgate_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_in(gate_in), .tmr_out(tmr_out), .irq_pulse(irq_pulse), .irq_flag(irq_flag),
    .count_q(count_q), .reload_q(reload_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] start, input logic [15:0] mat);
    wr(3'd0, start[15:8]); wr(3'd1, start[7:0]);
    wr(3'd2, mat[15:8]);   wr(3'd3, mat[7:0]);
  endtask

  task automatic setup(input logic [2:0] e, input logic lvl, input logic [1:0] src);
    wr(3'd4, {2'b00, src, lvl, e});
  endtask

  task automatic ctrl(input logic run, input logic mode, input logic pol, input logic oe);
    wr(3'd5, {4'b0000, oe, pol, mode, run});
  endtask

  task automatic gate_pulse(input int n);
    gate_in = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    gate_in = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count_q, 0);
    chk("R1 match", reload_q, 0);
    chk("R1 out", tmr_out, 0);
    chk("R1 pulse", irq_pulse, 0);
    chk("R1 flag", irq_flag, 0);
  endtask

  task automatic t_compare;
    setup(3'd1, 1'b0, 2'b00);
    load(16'h0001, 16'h0005);
    chk("R2 count bytes", count_q, 16'h0001);
    chk("R2 match bytes", reload_q, 16'h0005);
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    edges(9);
    chk("R5 before match count", count_q, 16'h0005);
    chk("R5 before match pulse", irq_pulse, 0);
    edges(1);
    chk("R5 match pulse", irq_pulse, 1);
    chk("R5 continues past match", count_q, 16'h0006);
    chk("R6 toggle with oe", tmr_out, 1);
    chk("R11 flag set", irq_flag, 1);
    edges(1);
    chk("R5 pulse one cycle", irq_pulse, 0);
  endtask

  task automatic t_wrap;
    ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd6, 8'h00);
    chk("R11 zero write keeps flag", irq_flag, 1);
    wr(3'd6, 8'h01);
    chk("R11 one write clears flag", irq_flag, 0);
    setup(3'd0, 1'b1, 2'b00);
    chk("R6 initial level load", tmr_out, 1);
    load(16'hFFFE, 16'h0003);
    ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    edges(1);
    chk("R7 reach FFFF", count_q, 16'hFFFF);
    edges(1);
    chk("R7 wrap to 0000", count_q, 16'h0000);
    chk("R7 no pulse at wrap", irq_pulse, 0);
    edges(4);
    chk("R5 match after wrap pulse", irq_pulse, 1);
    chk("R5 match after wrap count", count_q, 16'h0004);
    chk("R6 no toggle without oe", tmr_out, 1);
  endtask

  task automatic t_prescale_lock;
    ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    setup(3'd2, 1'b0, 2'b00);
    load(16'h0010, 16'h0100);
    ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    edges(3);
    chk("R4 no step before 2^N", count_q, 16'h0010);
    edges(1);
    chk("R4 first step at 2^N", count_q, 16'h0011);
    wr(3'd0, 8'hAA);
    wr(3'd2, 8'h55);
    wr(3'd4, 8'h08);
    chk("R3 count write ignored", count_q, 16'h0011);
    chk("R3 match write ignored", reload_q, 16'h0100);
    chk("R3 setup write ignored", tmr_out, 0);
    edges(1);
    chk("R4 second step", count_q, 16'h0012);
    edges(3);
    chk("R3 divider kept", count_q, 16'h0012);
    edges(1);
    chk("R4 third step", count_q, 16'h0013);
    ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    edges(20);
    chk("R12 frozen while stopped", count_q, 16'h0013);
    edges(1);
    ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    edges(3);
    chk("R12 divider restarted", count_q, 16'h0013);
    edges(1);
    chk("R12 step 2^N after run", count_q, 16'h0014);
  endtask

  task automatic t_gated;
    ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd6, 8'h01);
    setup(3'd0, 1'b0, 2'b01);
    load(16'h0001, 16'h0064);
    ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    edges(5);
    chk("R8 hold while inactive", count_q, 16'h0001);
    gate_pulse(5);
    edges(2);
    chk("R8 G steps", count_q, 16'h0006);
    chk("R10 no pulse yet", irq_pulse, 0);
    edges(1);
    chk("R10 deassert pulse", irq_pulse, 1);
    chk("R11 flag from deassert", irq_flag, 1);
    chk("R8 stopped after gate", count_q, 16'h0006);
    wr(3'd6, 8'h01);
    ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    edges(3);
    chk("R8 low active level counts", count_q, 16'h0009);
  endtask

  task automatic t_restart;
    ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd6, 8'h01);
    setup(3'd0, 1'b0, 2'b10);
    load(16'h0001, 16'h0003);
    ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    gate_pulse(3);
    edges(2);
    chk("R9 restart to 0001", count_q, 16'h0001);
    chk("R9 restart pulse", irq_pulse, 1);
    chk("R9 restart toggle", tmr_out, 1);
    wr(3'd6, 8'h01);
    gate_pulse(1);
    edges(5);
    chk("R8 single step", count_q, 16'h0002);
    chk("R10 deassert ignored when src bit0 clear", irq_flag, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(1);
    t_reset;
    t_compare;
    t_wrap;
    t_prescale_lock;
    t_gated;
    t_restart;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule